// File: doc/BRIEF.md
# Transmit Byte-Alignment Unpacker

This block sits between a host write port and the byte-wide transmit path. The host writes 32-bit words into a data port. For every buffer it writes two command words and then the buffer's data words. The first command word gives the buffer's byte count, its byte offset from the aligned base, the boundary to which the data phase is padded, and two flags that mark the buffer as the opening or closing piece of a packet. The second command word is taken in and not interpreted.

With these fields the block works out how many data words the host will send. It keeps only the bytes between the offset and the end of the buffer. Those bytes go out one per cycle on a valid/ready stream, with markers on the first and final bytes of a packet. The host can therefore move a buffer that starts at any byte address using plain aligned word writes or 16/32-byte bursts. Bursts may step through the eight aliased word addresses of the port.

Top module: `tx_align_unpacker`

## Requirements
- R1: After reset, out_valid, out_first and out_last are low and wr_ready is high. The next accepted word is taken as command word A.
- R2: A write is accepted when wr_en, an address hit and wr_ready are all high in the same cycle. The block takes command word A, then command word B, then the data words. Command word B has no effect on the byte stream.
- R3: With the default parameters, the data port answers at word addresses 0x20 to 0x27, and each of them is the same port. A write to any other address is ignored and changes neither the output nor the command/data sequence.
- R4: Command word A fields: buffer byte count in bits [10:0], last-segment flag in bit 12, first-segment flag in bit 13, start offset in bits [20:16] (0 to 31), end-alignment code in bits [25:24].
- R5: The start-offset bytes that come before the buffer data are dropped, even when they span several words. Exactly byte-count bytes are emitted per buffer.
- R6: Bytes within a data word leave in little-endian order: bits [7:0] first, then [15:8], [23:16] and [31:24].
- R7: The number of data words consumed is ceil((offset + count) / A) × A / 4. A is 4 bytes for code 00, 16 for code 01, 32 for code 10, and 4 for the reserved code 11. Pad bytes and pad words never reach the output. After the last of those words the next write is taken as command word A.
- R8: out_first is high with the first emitted byte of a buffer whose first-segment flag is set, and low with every other byte.
- R9: out_last is high with the final emitted byte of a buffer whose last-segment flag is set, and low with every other byte.
- R10: While out_valid is high and out_ready is low, out_data, out_first and out_last hold steady. wr_ready stays low while any byte of the current data word is still pending.
- R11: A buffer with count 0 and offset 0 takes no data words and emits no bytes. The word after its command word B is taken as the next command word A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W (8) | Host word address |
| wr_data | input | 32 | Host write data (command or buffer word) |
| wr_ready | output | 1 | Block can take a word this cycle |
| out_valid | output | 1 | A payload byte is presented |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Payload byte |
| out_first | output | 1 | Byte opens a packet |
| out_last | output | 1 | Byte closes a packet |

## Verification
The buffer patterns vary the offset from 0 to 31 and use all four end-alignment codes. They include buffers that end exactly on a boundary and buffers that need whole pad words, and the write address is rotated through the alias window. Each buffer follows the previous one without a reset, so a word-count error shows up as a broken following buffer. An offset error shows up as shifted byte values, a lane-order error as swapped bytes, and a flag error as misplaced markers. Directed cases hold the output stalled in mid-word, inject writes just outside the window, and send a zero-length buffer between two normal ones.

// File: rtl/txu_pkg.sv
package txu_pkg;

   // command word A layout
   localparam int CMD_SIZE_W    = 11;
   localparam int CMD_SIZE_LSB  = 0;
   localparam int CMD_LAST_BIT  = 12;
   localparam int CMD_FIRST_BIT = 13;
   localparam int CMD_OFS_W     = 5;
   localparam int CMD_OFS_LSB   = 16;
   localparam int CMD_ALIGN_LSB = 24;

   // end-alignment codes
   localparam logic [1:0] ALN_W4  = 2'b00;
   localparam logic [1:0] ALN_B16 = 2'b01;
   localparam logic [1:0] ALN_B32 = 2'b10;

   typedef enum logic [1:0] {
      ST_CMD_A = 2'd0,
      ST_CMD_B = 2'd1,
      ST_DATA  = 2'd2
   } txu_state_e;

   typedef struct packed {
      logic [CMD_OFS_W-1:0]  ofs;
      logic [CMD_SIZE_W-1:0] size;
      logic [1:0]            align;
      logic                  first;
      logic                  last;
   } txu_cmd_t;

endpackage

// File: rtl/txu_cmd_decode.sv
module txu_cmd_decode
   import txu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int TOT_W  = CMD_SIZE_W + 1,
   parameter int CNT_W  = TOT_W - 2
) (
   input  logic [DATA_W-1:0] cmd_word,
   output txu_cmd_t          cmd,
   output logic [CNT_W-1:0]  n_words
);

   logic [TOT_W-1:0] span;
   logic [TOT_W-1:0] rnd;
   logic             unused_bits;

   always_comb begin
      cmd.size  = cmd_word[CMD_SIZE_LSB +: CMD_SIZE_W];
      cmd.last  = cmd_word[CMD_LAST_BIT];
      cmd.first = cmd_word[CMD_FIRST_BIT];
      cmd.ofs   = cmd_word[CMD_OFS_LSB +: CMD_OFS_W];
      cmd.align = cmd_word[CMD_ALIGN_LSB +: 2];
   end

   assign span = TOT_W'(cmd.size) + TOT_W'(cmd.ofs);

   // round the span up to the boundary, then convert to words
   always_comb begin
      case (cmd.align)
         ALN_B16: begin
            rnd     = span + TOT_W'(15);
            n_words = CNT_W'({rnd[TOT_W-1:4], 2'b00});
         end
         ALN_B32: begin
            rnd     = span + TOT_W'(31);
            n_words = CNT_W'({rnd[TOT_W-1:5], 3'b000});
         end
         default: begin
            rnd     = span + TOT_W'(3);
            n_words = CNT_W'(rnd[TOT_W-1:2]);
         end
      endcase
   end

   assign unused_bits = ^{cmd_word[DATA_W-1:CMD_ALIGN_LSB+2],
                          cmd_word[CMD_ALIGN_LSB-1:CMD_OFS_LSB+CMD_OFS_W],
                          cmd_word[CMD_OFS_LSB-1:CMD_FIRST_BIT+1],
                          cmd_word[CMD_LAST_BIT-1:CMD_SIZE_LSB+CMD_SIZE_W]};

endmodule

// File: rtl/txu_seq.sv
module txu_seq
   import txu_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  txu_cmd_t         cmd_dec,
   input  logic [CNT_W-1:0] n_words_dec,
   output txu_state_e       state,
   output txu_cmd_t         cmd_q,
   output logic [CNT_W-1:0] word_idx
);

   logic [CNT_W-1:0] words_q;
   logic [CNT_W-1:0] idx_nxt;

   assign idx_nxt = word_idx + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_CMD_A;
         cmd_q    <= '0;
         words_q  <= '0;
         word_idx <= '0;
      end else if (acc) begin
         case (state)
            ST_CMD_A: begin
               cmd_q   <= cmd_dec;
               words_q <= n_words_dec;
               state   <= ST_CMD_B;
            end
            ST_CMD_B: begin
               word_idx <= '0;
               state    <= (words_q == '0) ? ST_CMD_A : ST_DATA;
            end
            ST_DATA: begin
               word_idx <= idx_nxt;
               if (idx_nxt == words_q) state <= ST_CMD_A;
            end
            default: state <= ST_CMD_A;
         endcase
      end
   end

endmodule

// File: rtl/txu_byte_out.sv
module txu_byte_out #(
   parameter int DATA_W = 32,
   parameter int OFS_W  = 5,
   parameter int SIZE_W = 11,
   parameter int CNT_W  = 10,
   parameter int TOT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] word,
   input  logic [CNT_W-1:0]  word_idx,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [SIZE_W-1:0] size,
   input  logic              first_seg,
   input  logic              last_seg,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [7:0]        out_data,
   output logic              out_first,
   output logic              out_last,
   output logic              busy
);

   localparam int LANES = DATA_W / 8;
   localparam int SEL_W = $clog2(LANES);

   logic [DATA_W-1:0] word_q;
   logic [LANES-1:0]  pend_q, first_q, last_q;
   logic [LANES-1:0]  pay_m, first_m, last_m;
   logic [SEL_W-1:0]  sel;
   logic [TOT_W-1:0]  beg_idx, end_idx;

   assign beg_idx = TOT_W'(ofs);
   assign end_idx = TOT_W'(ofs) + TOT_W'(size);

   // per-lane classification of the incoming word
   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [TOT_W-1:0] idx;
      assign idx        = TOT_W'({word_idx, SEL_W'(ln)});
      assign pay_m[ln]   = (idx >= beg_idx) && (idx < end_idx);
      assign first_m[ln] = pay_m[ln] && first_seg && (idx == beg_idx);
      assign last_m[ln]  = pay_m[ln] && last_seg && (idx == end_idx - TOT_W'(1));
   end

   // lowest pending lane goes out first
   always_comb begin
      sel = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (pend_q[i]) sel = SEL_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         pend_q  <= '0;
         first_q <= '0;
         last_q  <= '0;
      end else if (load) begin
         word_q  <= word;
         pend_q  <= pay_m;
         first_q <= first_m;
         last_q  <= last_m;
      end else if (out_valid && out_ready) begin
         pend_q[sel] <= 1'b0;
      end
   end

   assign busy      = |pend_q;
   assign out_valid = busy;
   assign out_data  = word_q[{sel, 3'b000} +: 8];
   assign out_first = busy && first_q[sel];
   assign out_last  = busy && last_q[sel];

endmodule

// File: rtl/tx_align_unpacker.sv
module tx_align_unpacker
   import txu_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter int          DATA_W      = 32,
   parameter int          ALIAS_WORDS = 8,
   parameter logic [7:0]  PORT_BASE   = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              out_first,
   output logic              out_last
);

   localparam int TOT_W  = CMD_SIZE_W + 1;
   localparam int CNT_W  = TOT_W - 2;
   localparam int ALS_W  = (ALIAS_WORDS > 1) ? $clog2(ALIAS_WORDS) : 1;
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(PORT_BASE);

   initial begin
      if (DATA_W != 32)
         $error("tx_align_unpacker: DATA_W must be 32");
      if ((ALIAS_WORDS & (ALIAS_WORDS - 1)) != 0)
         $error("tx_align_unpacker: ALIAS_WORDS must be a power of two");
      if ((int'(PORT_BASE) % ALIAS_WORDS) != 0)
         $error("tx_align_unpacker: PORT_BASE must be aligned to the window");
      if (ALS_W >= ADDR_W)
         $error("tx_align_unpacker: window wider than address");
   end

   logic             hit, acc, busy;
   txu_state_e       state;
   txu_cmd_t         cmd_dec, cmd_q;
   logic [CNT_W-1:0] n_words_dec, word_idx;
   logic             unused_bits;

   // address window decode
   if (ALIAS_WORDS == 1) begin : g_single
      assign hit = (wr_addr == BASE_A);
      assign unused_bits = ^cmd_q.align;
   end else begin : g_window
      assign hit = (wr_addr[ADDR_W-1:ALS_W] == BASE_A[ADDR_W-1:ALS_W]);
      assign unused_bits = ^{cmd_q.align, wr_addr[ALS_W-1:0]};
   end

   assign wr_ready = !busy;
   assign acc      = wr_en && hit && wr_ready;

   txu_cmd_decode #(
      .DATA_W (DATA_W),
      .TOT_W  (TOT_W),
      .CNT_W  (CNT_W)
   ) u_dec (
      .cmd_word (wr_data),
      .cmd      (cmd_dec),
      .n_words  (n_words_dec)
   );

   txu_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc         (acc),
      .cmd_dec     (cmd_dec),
      .n_words_dec (n_words_dec),
      .state       (state),
      .cmd_q       (cmd_q),
      .word_idx    (word_idx)
   );

   txu_byte_out #(
      .DATA_W (DATA_W),
      .OFS_W  (CMD_OFS_W),
      .SIZE_W (CMD_SIZE_W),
      .CNT_W  (CNT_W),
      .TOT_W  (TOT_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (acc && (state == ST_DATA)),
      .word      (wr_data),
      .word_idx  (word_idx),
      .ofs       (cmd_q.ofs),
      .size      (cmd_q.size),
      .first_seg (cmd_q.first),
      .last_seg  (cmd_q.last),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_first (out_first),
      .out_last  (out_last),
      .busy      (busy)
   );

endmodule

// File: rtl/txu_chk.sv
module txu_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_ready,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_data,
   input logic       out_first,
   input logic       out_last
);

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)
         && $stable(out_first) && $stable(out_last)); // R10

   AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !wr_ready); // R10

   AST_FIRST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_first |-> out_valid); // R8

   AST_LAST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid); // R9

   AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> !out_valid); // R2

   AST_DATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !$isunknown(out_data)); // R6

endmodule

bind tx_align_unpacker txu_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_ready  (wr_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_first (out_first),
   .out_last  (out_last)
);

// File: tb/sim_tx_align_unpacker.sv
module sim_tx_align_unpacker;

   localparam logic [7:0] BASE = 8'h20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        wr_ready;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [7:0]  out_data;
   logic        out_first;
   logic        out_last;

   always #5 clk = ~clk;

   tx_align_unpacker u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_ready  (wr_ready),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_first (out_first),
      .out_last  (out_last)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   // vector: ofs[30:26] size[25:15] align[14:13] first[12] last[11] asel[10:8] seed[7:0]
   localparam int NVEC = 9;
   localparam logic [30:0] VEC [0:NVEC-1] = '{
      {5'd0,  11'd8,   2'd0, 1'b1, 1'b1, 3'd0, 8'h11},
      {5'd3,  11'd5,   2'd0, 1'b1, 1'b0, 3'd1, 8'h22},
      {5'd1,  11'd1,   2'd1, 1'b0, 1'b1, 3'd2, 8'h33},
      {5'd31, 11'd6,   2'd2, 1'b1, 1'b1, 3'd7, 8'h44},
      {5'd2,  11'd13,  2'd3, 1'b1, 1'b1, 3'd3, 8'h55},
      {5'd0,  11'd1,   2'd2, 1'b1, 1'b1, 3'd4, 8'h66},
      {5'd5,  11'd40,  2'd1, 1'b0, 1'b0, 3'd5, 8'h77},
      {5'd16, 11'd16,  2'd2, 1'b1, 1'b0, 3'd6, 8'h88},
      {5'd7,  11'd100, 2'd0, 1'b0, 1'b1, 3'd0, 8'h99}
   };

   logic [7:0] got_b [0:1023];
   logic       got_f [0:1023];
   logic       got_l [0:1023];
   int         got_n = 0;

   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (got_n < 1024) begin
            got_b[got_n] = out_data;
            got_f[got_n] = out_first;
            got_l[got_n] = out_last;
         end
         got_n++;
      end
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         summary();
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
      return 8'(k * 29 + (k >> 4)) ^ seed;
   endfunction

   function automatic logic [31:0] cmd_a(input int ofs, input int size,
                                         input int aln, input bit f, input bit l);
      return {6'd0, 2'(aln), 3'd0, 5'(ofs), 2'd0, f, l, 1'b0, 11'(size)};
   endfunction

   // called at a falling edge; returns at the falling edge after acceptance
   task automatic put(input logic [7:0] a, input logic [31:0] d);
      logic took;
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      do begin
         took = wr_ready;
         @(negedge clk);
      end while (!took);
      wr_en = 1'b0;
   endtask

   task automatic send_words(input int ofs, input int size, input int aln,
                             input int asel, input logic [7:0] seed, input int from);
      int a_bytes, nw;
      a_bytes = (aln == 1) ? 16 : (aln == 2) ? 32 : 4;
      nw = ((ofs + size + a_bytes - 1) / a_bytes) * a_bytes / 4;
      for (int w = from; w < nw; w++) begin
         put(BASE + 8'((asel + 2 + w) & 7),
             {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)});
      end
   endtask

   task automatic check_stream(input int ofs, input int size, input bit f,
                               input bit l, input logic [7:0] seed, input int id);
      int errs, ferr, lerr, bad_act, bad_exp;
      errs = 0; ferr = 0; lerr = 0; bad_act = 0; bad_exp = 0;
      check(got_n == size, "R5", $sformatf("vec %0d byte count", id), got_n, size);
      for (int j = 0; j < size && j < got_n; j++) begin
         if (got_b[j] !== pat(seed, ofs + j)) begin
            if (errs == 0) begin
               bad_act = int'(got_b[j]);
               bad_exp = int'(pat(seed, ofs + j));
            end
            errs++;
         end
         if (got_f[j] !== (f && j == 0)) ferr++;
         if (got_l[j] !== (l && j == size - 1)) lerr++;
      end
      check(errs == 0, "R6 R7", $sformatf("vec %0d payload byte", id), bad_act, bad_exp);
      check(ferr == 0, "R8", $sformatf("vec %0d first marker errors", id), ferr, 0);
      check(lerr == 0, "R9", $sformatf("vec %0d last marker errors", id), lerr, 0);
   endtask

   task automatic run_buf(input int ofs, input int size, input int aln, input bit f,
                          input bit l, input int asel, input logic [7:0] seed, input int id);
      got_n = 0;
      put(BASE + 8'(asel), cmd_a(ofs, size, aln, f, l));
      put(BASE + 8'((asel + 1) & 7), 32'hDEAD_0000 | 32'(size)); // R2: B is ignored
      send_words(ofs, size, aln, asel, seed, 0);
      repeat (6) @(negedge clk);
      check_stream(ofs, size, f, l, seed, id);
   endtask

   initial begin
      logic [7:0] held_b;
      // R1: reset state
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
      check(wr_ready == 1'b1, "R1", "wr_ready in reset", int'(wr_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && !out_first && !out_last, "R1", "outputs idle after reset",
            int'({out_valid, out_first, out_last}), 0);

      // table of buffer patterns, chained without reset (R4 R5 R6 R7 R3 alias)
      for (int i = 0; i < NVEC; i++) begin
         run_buf(int'(VEC[i][30:26]), int'(VEC[i][25:15]), int'(VEC[i][14:13]),
                 VEC[i][12], VEC[i][11], int'(VEC[i][10:8]), VEC[i][7:0], i);
      end

      // R3: writes just outside the window are ignored
      wr_en = 1'b1; wr_addr = 8'h28; wr_data = cmd_a(0, 4, 0, 1, 1);
      repeat (2) @(negedge clk);
      wr_addr = 8'h1F;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, "R3", "no output after outside writes", int'(out_valid), 0);
      run_buf(2, 9, 0, 1, 1, 6, 8'hA1, 100); // R3 sequence intact

      // R11: zero-length buffer takes no data words
      got_n = 0;
      put(BASE + 8'd3, cmd_a(0, 0, 2, 1, 1));
      put(BASE + 8'd4, 32'h0);
      repeat (3) @(negedge clk);
      check(got_n == 0 && !out_valid, "R11", "zero-length emits nothing", got_n, 0);
      run_buf(1, 7, 1, 1, 1, 5, 8'hB2, 101); // R11 next word was command A

      // R10: stall in mid-word
      got_n = 0;
      out_ready = 1'b0;
      put(BASE, cmd_a(1, 6, 0, 1, 1));
      put(BASE + 8'd1, 32'h0);
      put(BASE + 8'd2, {pat(8'hC3, 3), pat(8'hC3, 2), pat(8'hC3, 1), pat(8'hC3, 0)});
      @(negedge clk);
      check(out_valid == 1'b1, "R10", "byte presented while stalled", int'(out_valid), 1);
      check(out_data == pat(8'hC3, 1), "R10", "stalled byte value",
            int'(out_data), int'(pat(8'hC3, 1)));
      check(wr_ready == 1'b0, "R10", "wr_ready low while pending", int'(wr_ready), 0);
      held_b = out_data;
      repeat (3) @(negedge clk);
      check(out_data == held_b && out_first == 1'b1, "R10", "stall holds byte and marker",
            int'(out_data), int'(held_b));
      check(wr_ready == 1'b0, "R10", "wr_ready still low", int'(wr_ready), 0);
      out_ready = 1'b1;
      put(BASE + 8'd3, {pat(8'hC3, 7), pat(8'hC3, 6), pat(8'hC3, 5), pat(8'hC3, 4)});
      repeat (6) @(negedge clk);
      check_stream(1, 6, 1'b1, 1'b1, 8'hC3, 102);

      summary();
      $finish;
   end

endmodule